// File: doc/BRIEF.md
# Synchronous Presettable Decade Counter

This block is one BCD digit of a counter. It steps 0, 1, … 9 and back to 0 on the rising clock edge. A parallel value can be preset on an edge. An active-low clear zeroes the digit at once, with no clock edge needed. A terminal-count output is raised while the digit sits at 9 and its trickle enable is high. Tie that output to the trickle enable of the next digit to build a chain of any length. Because the terminal count is a plain combinational gate of the local state and the local trickle enable, each stage only waits on the gate of the stage just below it.

Two enables qualify counting. The parallel enable is usually shared by every digit. The trickle enable carries the chain. The digit counts only when both are high, while the terminal count depends on the trickle enable alone. A preset may load any 4-bit code, including 10 to 15. From those codes the digit steps up by one, and 15 rolls over to 0, so it rejoins the decimal sequence after a few edges. A synchronous active-high `rst` is also present as the chip-level reset.

Top module: `decade_counter`

## Requirements
- R1: While `clr_n` is low, `q` reads 0000 at once, with no clock edge needed.
- R2: With `clr_n` high, a high `rst` at a rising edge makes `q` 0000. `rst` takes precedence over preset and counting.
- R3: With `clr_n` high and `rst` low, a low `load_n` at a rising edge copies `din` into `q`, whatever the enables are.
- R4: With `clr_n` high, `rst` low, `load_n` high and both `en_p` and `en_t` high, each rising edge advances `q` by one in the order 0,1,…,9,0.
- R5: When `en_p` or `en_t` is low, and no clear, reset or preset is active, `q` keeps its value across the edge.
- R6: `carry` is high exactly when `en_t` is high and `q` equals 9 (1001). It is combinational, so it follows `en_t` within the same cycle and does not depend on `en_p`.
- R7: When counting from a preset code of 10 to 14, `q` becomes `q`+1. From 15 it becomes 0.
- R8: When two digits are chained, with the upper digit's `en_t` taken from the lower digit's `carry`, the pair runs 00 through 99 and then wraps to 00. The upper digit advances only on the edge where the lower digit leaves 9.
- R9: A low `clr_n` overrides a simultaneous preset: `q` stays 0000 across an edge that has `load_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0 |
| clr_n | input | 1 | Asynchronous active-low clear |
| load_n | input | 1 | Synchronous active-low preset |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable, which also gates `carry` |
| din | input | 4 | Preset value |
| q | output | 4 | Current digit |
| carry | output | 1 | Terminal count for the next stage |

## Verification
Presets, counts, holds and the reset each show on `q` one rising edge after they are applied. The bench drives inputs 1 ns after an edge, advances its model at the next edge, and compares 1 ns after that edge. `carry` and the asynchronous clear act with no edge. The bench checks these a short settle time after changing the input, in the middle of a clock period. Every cycle compares both digits of a two-stage chain and both terminal counts against the model.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int DIGIT_W   = 4;
    localparam int TOP_DIGIT = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    // next-state selection, in priority order below clear
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_ZERO  = 2'd3
    } op_e;

    typedef struct packed {
        logic rst;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctrl_t;

    function automatic logic is_top(digit_t d);
        return d == digit_t'(TOP_DIGIT);
    endfunction

    // decimal step; codes above the top digit step by one and wrap at all-ones
    function automatic digit_t step_digit(digit_t d);
        if (is_top(d)) return '0;
        return d + digit_t'(1);
    endfunction

endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
    import decade_pkg::*;
(
    input  ctrl_t ctrl,
    output op_e   op
);
    always_comb begin
        if (ctrl.rst)                    op = OP_ZERO;
        else if (!ctrl.load_n)           op = OP_LOAD;
        else if (ctrl.en_p && ctrl.en_t) op = OP_COUNT;
        else                             op = OP_HOLD;
    end
endmodule

// File: rtl/decade_next.sv
module decade_next
    import decade_pkg::*;
(
    input  op_e    op,
    input  digit_t cur,
    input  digit_t din,
    output digit_t nxt
);
    always_comb begin
        unique case (op)
            OP_ZERO:  nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = step_digit(cur);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/decade_reg.sv
module decade_reg
    import decade_pkg::*;
(
    input  logic   clk,
    input  logic   clr_n,
    input  digit_t nxt,
    output digit_t cur
);
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cur <= '0;
        else        cur <= nxt;
    end
endmodule

// File: rtl/decade_carry.sv
module decade_carry
    import decade_pkg::*;
(
    input  logic   en_t,
    input  digit_t cur,
    output logic   tc
);
    assign tc = en_t & is_top(cur);
endmodule

// File: rtl/decade_counter.sv
module decade_counter
    import decade_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [DIGIT_W-1:0] din,
    output logic [DIGIT_W-1:0] q,
    output logic               carry
);
    ctrl_t  ctrl;
    op_e    op;
    digit_t cur;
    digit_t nxt;

    assign ctrl = '{rst: rst, load_n: load_n, en_p: en_p, en_t: en_t};

    decade_ctrl  u_ctrl  (.ctrl(ctrl), .op(op));
    decade_next  u_next  (.op(op), .cur(cur), .din(din), .nxt(nxt));
    decade_reg   u_reg   (.clk(clk), .clr_n(clr_n), .nxt(nxt), .cur(cur));
    decade_carry u_carry (.en_t(en_t), .cur(cur), .tc(carry));

    assign q = cur;
endmodule

// File: rtl/decade_counter_chk.sv
module decade_counter_chk
    import decade_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               clr_n,
    input logic               load_n,
    input logic               en_p,
    input logic               en_t,
    input logic [DIGIT_W-1:0] din,
    input logic [DIGIT_W-1:0] q,
    input logic               carry
);
    logic run;
    assign run = load_n && en_p && en_t;

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> q == '0);

    assert_reset_zero_R2: assert property (@(posedge clk) disable iff (!clr_n)
        rst |=> q == '0);

    assert_preset_R3: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !load_n |=> q == $past(din));

    assert_count_up_R4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        run && q < 4'd9 |=> q == $past(q) + 4'd1);

    assert_count_wrap_R4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        run && q == 4'd9 |=> q == '0);

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        load_n && !(en_p && en_t) |=> $stable(q));

    assert_carry_needs_top_R6: assert property (@(posedge clk) disable iff (rst)
        carry |-> (q == 4'd9 && en_t));

    assert_carry_present_R6: assert property (@(posedge clk) disable iff (rst)
        (q == 4'd9 && en_t) |-> carry);

    assert_high_codes_R7: assert property (@(posedge clk) disable iff (rst || !clr_n)
        run && q > 4'd9 && q < 4'd15 |=> q == $past(q) + 4'd1);

    assert_all_ones_wrap_R7: assert property (@(posedge clk) disable iff (rst || !clr_n)
        run && q == 4'd15 |=> q == '0);

    assert_clear_over_load_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !load_n) |-> q == '0);
endmodule

bind decade_counter decade_counter_chk u_chk (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q), .carry(carry)
);

// File: tb/test_decade_counter.sv
`timescale 1ns/1ps
module test_decade_counter;
    localparam real HALF = 2.0;

    logic clk = 0;
    logic rst = 1, clr_n = 1, ld_lo = 1, ld_hi = 1, en_p = 0, en_t = 0;
    logic [3:0] d_lo = 0, d_hi = 0;
    logic [3:0] q_lo, q_hi;
    logic c_lo, c_hi;

    int total = 0, bad = 0;
    int m_lo = 0, m_hi = 0;

    always #(HALF) clk = ~clk;

    decade_counter i_decade_counter (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(ld_lo), .en_p(en_p),
        .en_t(en_t), .din(d_lo), .q(q_lo), .carry(c_lo));

    decade_counter i_decade_counter_tens (
        .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(ld_hi), .en_p(en_p),
        .en_t(c_lo), .din(d_hi), .q(q_hi), .carry(c_hi));

    function automatic int ref_next(int cur, logic ld, logic [3:0] d, logic ep, logic et);
        if (!clr_n || rst) return 0;
        if (!ld) return int'(d);
        if (ep && et) return (cur == 9) ? 0 : (cur + 1) % 16;
        return cur;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        bit ref_c_lo, ref_c_hi;
        ref_c_lo = en_t && m_lo == 9;
        ref_c_hi = ref_c_lo && m_hi == 9;
        check(req, "q_lo", int'(q_lo), m_lo);
        check(req, "q_hi", int'(q_hi), m_hi);
        check(req, "carry_lo", int'(c_lo), int'(ref_c_lo));
        check(req, "carry_hi", int'(c_hi), int'(ref_c_hi));
    endtask

    // inputs are set before the call; one edge, then compare
    task automatic tick(string req);
        int n_lo, n_hi;
        bit cl;
        cl = en_t && m_lo == 9;
        n_lo = ref_next(m_lo, ld_lo, d_lo, en_p, en_t);
        n_hi = ref_next(m_hi, ld_hi, d_hi, en_p, cl);
        @(posedge clk);
        #1;
        m_lo = n_lo;
        m_hi = n_hi;
        check_all(req);
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        // R2: reset state
        tick("R2"); tick("R2");
        rst = 0; en_p = 1; en_t = 1;
        // R4 R6 R8: chain 00..99 then wrap, plus some extra
        for (int i = 0; i < 105; i++) tick("R8");
        check("R8", "wrapped tens", int'(q_hi), 0);
        // R5: parallel enable low
        en_p = 0;
        for (int i = 0; i < 4; i++) tick("R5");
        // R3: preset 9 on both with enables off
        ld_lo = 0; ld_hi = 0; d_lo = 9; d_hi = 9; tick("R3");
        ld_lo = 1; ld_hi = 1;
        // R6: carry follows en_t within the cycle, en_p low
        en_t = 1; #0.5; check_all("R6");
        en_t = 0; #0.5; check_all("R6");
        tick("R5"); tick("R5");
        en_t = 1; #0.5; check_all("R6");
        // R4 R8: both digits leave 9 together
        en_p = 1; tick("R8");
        // R3: preset overrides counting
        ld_lo = 0; d_lo = 4; tick("R3");
        d_lo = 7; tick("R3");
        ld_lo = 1;
        // R7: out-of-range codes
        ld_lo = 0; d_lo = 12; tick("R7");
        ld_lo = 1;
        for (int i = 0; i < 5; i++) tick("R7");
        ld_lo = 0; d_lo = 15; tick("R7");
        ld_lo = 1; tick("R7"); tick("R7");
        // R7: held high code does not move
        ld_lo = 0; d_lo = 11; tick("R7");
        ld_lo = 1; en_p = 0; tick("R5"); en_p = 1; tick("R7");
        for (int i = 0; i < 6; i++) tick("R4");
        // R1: async clear mid-cycle, no edge
        #0.5; clr_n = 0; #0.3;
        m_lo = 0; m_hi = 0;
        check_all("R1");
        // R9: clear held across an edge with preset low
        ld_lo = 0; ld_hi = 0; d_lo = 6; d_hi = 3;
        tick("R9"); tick("R9");
        clr_n = 1; ld_lo = 1; ld_hi = 1;
        for (int i = 0; i < 13; i++) tick("R4");
        // R2: synchronous reset over preset and count
        rst = 1; ld_lo = 0; d_lo = 5; tick("R2");
        rst = 0; ld_lo = 1; tick("R4");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule